// File: doc/BRIEF.md
# Effective Address Calculation Unit

This unit is the address generator of a CISC-style execution pipeline. Each clock it can take one decoded operand descriptor and turn it into an effective address. The descriptor is a 6-bit mode/register field, an operand size and a few qualifiers. The data comes with it: the base register value, the program counter, an index register value and the already fetched extension data. Register reads, extension-word fetching and the memory access itself are done elsewhere. This unit only forms the address and the register update that goes with it.

The address is the base (an address register, the program counter, or nothing for absolute forms), plus a sign-extended displacement, plus an index that can be shifted left by 0 to 3 bits. All three are added in one cycle. Post-increment and pre-decrement forms also produce the updated base value in the same cycle as the access address. The register update therefore runs beside the memory access and needs no extra micro-op. In a load-effective-address request, the computed address is sent to a destination register and no memory access is made.

The unit also reports how many extension bytes the operand uses. It flags encodings that cannot be used: unused sub-codes, a program-counter-relative or immediate operand used as a write target, and an address-load request on a mode that has no control address. All results are registered, with one cycle of latency.

Top module: `eff_addr_unit`

## Requirements
- R1: While reset is asserted, and on the first sampling after reset, `addr_valid`, `wb_valid` and `illegal` are 0 and `ext_len` is 0.
- R2: A request presented with `req_valid` in one cycle produces its results on the outputs after the next rising clock edge. Requests on consecutive clocks each produce their own result on consecutive cycles.
- R3: Mode 010 (indirect) gives address = base. Mode 101 gives base + the sign-extended low 16 bits of `ext_data`. Both assert `addr_valid`.
- R4: Mode 110 gives base + the sign-extended low 8 bits of `ext_data` + (index << `idx_scale`). The index is the full `idx_val` when `idx_long`=1, and the sign-extended low 16 bits when `idx_long`=0.
- R5: Mode 011 (post-increment) gives address = the old base. In the same cycle it gives `wb_valid`=1 with `wb_value` = base + step and `wb_reg` = `ea_field[2:0]`. The step is 1, 2 or 4 for `op_size` 00, 01 and 1x.
- R6: Mode 100 (pre-decrement) gives address = `wb_value` = base − step, with both valids high.
- R7: Mode 111 with sub-code 000 gives the sign-extended low 16 bits of `ext_data` as the address. Sub-code 001 gives the full 32-bit `ext_data`.
- R8: Sub-code 010 gives `pc_val` + sext16, and sub-code 011 gives `pc_val` + sext8 + scaled index, for read requests.
- R9: The following raise `illegal`=1 with both valids 0: mode 111 with sub-code 101, 110 or 111; a PC-relative or immediate operand with `is_write`=1; a `lea_op` request on modes 000, 001, 011, 100 or immediate.
- R10: `ext_len` is the extension byte count. It is 0 for modes 000 to 100. It is 2 for modes 101 and 110 and for sub-codes 000, 010 and 011. It is 4 for sub-code 001. For immediate (sub-code 100) it is 4 when `op_size[1]`=1 and 2 otherwise. It is 0 for an illegal request.
- R11: Register-direct modes (000, 001) and immediate produce no address and no writeback, and are not illegal.
- R12: With `lea_op`=1 on a control mode, the address goes to `wb_value` with `wb_valid`=1 and `wb_reg`=`lea_dst`, and `addr_valid`=0.
- R13: A cycle with `req_valid`=0 leaves `addr_valid`, `wb_valid` and `illegal` at 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A descriptor is presented this cycle |
| ea_field | input | 6 | Mode in bits 5:3, register or sub-code in bits 2:0 |
| is_write | input | 1 | Operand is a write destination |
| lea_op | input | 1 | Load the address into a register instead of accessing memory |
| lea_dst | input | 3 | Destination register number for `lea_op` |
| op_size | input | 2 | 00 byte, 01 word, 1x long |
| base_val | input | 32 | Value of the base address register |
| pc_val | input | 32 | Program counter for PC-relative forms |
| idx_val | input | 32 | Index register value |
| idx_long | input | 1 | 1: full index, 0: sign-extended low word |
| idx_scale | input | 2 | Index left shift of 0 to 3 bits |
| ext_data | input | 32 | Fetched extension data (displacement or absolute address) |
| addr_valid | output | 1 | `addr_out` is a memory access address |
| addr_out | output | 32 | Effective address |
| wb_valid | output | 1 | A register update is requested |
| wb_reg | output | 3 | Register number to update |
| wb_value | output | 32 | Value to write into `wb_reg` |
| ext_len | output | 3 | Extension bytes used by the operand |
| illegal | output | 1 | The descriptor is not usable |

## Verification
The two functions that share a cycle are the access address and the base-register update. They meet in the post-increment and pre-decrement modes. The vector walk sends these modes back to back with other modes and with byte, word and long sizes. Each result is checked in the cycle after its request. The check confirms that the address equals the old base (post-increment) or the new base (pre-decrement), and that the writeback differs from it by exactly the size step in that same cycle. The address-load request is then sent on the same modes to show that it is refused, while on a displacement mode it moves the sum to the register path alone.

// File: rtl/eau_pkg.sv
package eau_pkg;

  typedef enum logic [1:0] {SRC_NONE, SRC_BASE, SRC_PC} src_e;
  typedef enum logic [1:0] {DSP_NONE, DSP_S8, DSP_S16, DSP_FULL} dsp_e;
  typedef enum logic [1:0] {UPD_NONE, UPD_INC, UPD_DEC, UPD_LEA} upd_e;

  typedef struct packed {
    src_e       src;
    dsp_e       dsp;
    logic       use_idx;
    upd_e       upd;
    logic       mem;
    logic [2:0] ext_len;
    logic       illegal;
  } ea_dec_t;

  // Size step in bytes: byte 1, word 2, long 4.
  function automatic logic [2:0] step_bytes(input logic [1:0] sz);
    case (sz)
      2'b00:   step_bytes = 3'd1;
      2'b01:   step_bytes = 3'd2;
      default: step_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/eau_mode_decode.sv
module eau_mode_decode
  import eau_pkg::*;
(
  input  logic [5:0] ea_field,
  input  logic       is_write,
  input  logic       lea_op,
  input  logic [1:0] op_size,
  output ea_dec_t    dec
);
  logic [2:0] mode;
  logic [2:0] sub;
  logic       ctrl_ok;
  logic       pc_rel;
  logic       imm;
  logic       bad_code;
  ea_dec_t    raw;

  assign mode = ea_field[5:3];
  assign sub  = ea_field[2:0];

  always_comb begin
    raw      = '0;
    raw.src  = SRC_NONE;
    raw.dsp  = DSP_NONE;
    raw.upd  = UPD_NONE;
    ctrl_ok  = 1'b0;
    pc_rel   = 1'b0;
    imm      = 1'b0;
    bad_code = 1'b0;
    case (mode)
      3'b010: begin raw.src = SRC_BASE; raw.mem = 1'b1; ctrl_ok = 1'b1; end
      3'b011: begin raw.src = SRC_BASE; raw.mem = 1'b1; raw.upd = UPD_INC; end
      3'b100: begin raw.src = SRC_BASE; raw.mem = 1'b1; raw.upd = UPD_DEC; end
      3'b101: begin
        raw.src = SRC_BASE; raw.dsp = DSP_S16; raw.mem = 1'b1;
        raw.ext_len = 3'd2; ctrl_ok = 1'b1;
      end
      3'b110: begin
        raw.src = SRC_BASE; raw.dsp = DSP_S8; raw.use_idx = 1'b1;
        raw.mem = 1'b1; raw.ext_len = 3'd2; ctrl_ok = 1'b1;
      end
      3'b111: begin
        case (sub)
          3'b000: begin raw.dsp = DSP_S16;  raw.mem = 1'b1; raw.ext_len = 3'd2; ctrl_ok = 1'b1; end
          3'b001: begin raw.dsp = DSP_FULL; raw.mem = 1'b1; raw.ext_len = 3'd4; ctrl_ok = 1'b1; end
          3'b010: begin
            raw.src = SRC_PC; raw.dsp = DSP_S16; raw.mem = 1'b1;
            raw.ext_len = 3'd2; ctrl_ok = 1'b1; pc_rel = 1'b1;
          end
          3'b011: begin
            raw.src = SRC_PC; raw.dsp = DSP_S8; raw.use_idx = 1'b1; raw.mem = 1'b1;
            raw.ext_len = 3'd2; ctrl_ok = 1'b1; pc_rel = 1'b1;
          end
          3'b100: begin
            imm = 1'b1;
            raw.ext_len = op_size[1] ? 3'd4 : 3'd2;
          end
          default: bad_code = 1'b1;
        endcase
      end
      default: ; // register direct: no address, no update
    endcase
  end

  always_comb begin
    dec = raw;
    if (lea_op) begin
      dec.mem     = 1'b0;
      dec.upd     = UPD_LEA;
      dec.illegal = bad_code | ~ctrl_ok;
    end else begin
      dec.illegal = bad_code | (is_write & (pc_rel | imm));
    end
  end

endmodule

// File: rtl/eau_index_scale.sv
module eau_index_scale #(
  parameter int AW  = 32,
  parameter int SHW = 2
) (
  input  logic [AW-1:0]  idx_val,
  input  logic           idx_long,
  input  logic [SHW-1:0] idx_scale,
  output logic [AW-1:0]  scaled
);
  localparam int HW = 16;

  logic [AW-1:0] stage [SHW+1];

  assign stage[0] = idx_long ? idx_val
                             : {{(AW-HW){idx_val[HW-1]}}, idx_val[HW-1:0]};

  for (genvar k = 0; k < SHW; k++) begin : g_shift
    assign stage[k+1] = idx_scale[k] ? (stage[k] << (1 << k)) : stage[k];
  end

  assign scaled = stage[SHW];

endmodule

// File: rtl/eau_sum.sv
module eau_sum
  import eau_pkg::*;
#(
  parameter int AW = 32
) (
  input  src_e          src,
  input  dsp_e          dsp,
  input  logic          use_idx,
  input  upd_e          upd,
  input  logic [1:0]    op_size,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] pc_val,
  input  logic [AW-1:0] ext_data,
  input  logic [AW-1:0] scaled_idx,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] wb
);
  localparam int S8  = 8;
  localparam int S16 = 16;

  logic [AW-1:0] base_sel;
  logic [AW-1:0] disp;
  logic [AW-1:0] idx_term;
  logic [AW-1:0] sum;
  logic [AW-1:0] step;

  always_comb begin
    case (src)
      SRC_BASE: base_sel = base_val;
      SRC_PC:   base_sel = pc_val;
      default:  base_sel = '0;
    endcase
    case (dsp)
      DSP_S8:   disp = {{(AW-S8){ext_data[S8-1]}}, ext_data[S8-1:0]};
      DSP_S16:  disp = {{(AW-S16){ext_data[S16-1]}}, ext_data[S16-1:0]};
      DSP_FULL: disp = ext_data;
      default:  disp = '0;
    endcase
    idx_term = use_idx ? scaled_idx : '0;
    sum      = base_sel + disp + idx_term;
    step     = AW'(step_bytes(op_size));
    case (upd)
      UPD_INC: begin addr = base_sel;        wb = base_sel + step; end
      UPD_DEC: begin addr = base_sel - step; wb = base_sel - step; end
      default: begin addr = sum;             wb = sum;             end
    endcase
  end

endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
  import eau_pkg::*;
#(
  parameter int AW  = 32,
  parameter int RW  = 3,
  parameter int SHW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [5:0]     ea_field,
  input  logic           is_write,
  input  logic           lea_op,
  input  logic [RW-1:0]  lea_dst,
  input  logic [1:0]     op_size,
  input  logic [AW-1:0]  base_val,
  input  logic [AW-1:0]  pc_val,
  input  logic [AW-1:0]  idx_val,
  input  logic           idx_long,
  input  logic [SHW-1:0] idx_scale,
  input  logic [AW-1:0]  ext_data,
  output logic           addr_valid,
  output logic [AW-1:0]  addr_out,
  output logic           wb_valid,
  output logic [RW-1:0]  wb_reg,
  output logic [AW-1:0]  wb_value,
  output logic [2:0]     ext_len,
  output logic           illegal
);
  // reset synchronizer: assert asynchronously, release on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  ea_dec_t       dec;
  logic [AW-1:0] scaled_idx;
  logic [AW-1:0] addr_c;
  logic [AW-1:0] wb_c;

  eau_mode_decode u_dec (
    .ea_field (ea_field),
    .is_write (is_write),
    .lea_op   (lea_op),
    .op_size  (op_size),
    .dec      (dec)
  );

  eau_index_scale #(.AW(AW), .SHW(SHW)) u_idx (
    .idx_val   (idx_val),
    .idx_long  (idx_long),
    .idx_scale (idx_scale),
    .scaled    (scaled_idx)
  );

  eau_sum #(.AW(AW)) u_sum (
    .src        (dec.src),
    .dsp        (dec.dsp),
    .use_idx    (dec.use_idx),
    .upd        (dec.upd),
    .op_size    (op_size),
    .base_val   (base_val),
    .pc_val     (pc_val),
    .ext_data   (ext_data),
    .scaled_idx (scaled_idx),
    .addr       (addr_c),
    .wb         (wb_c)
  );

  // next-state
  logic          addr_v_n, wb_v_n, ill_n;
  logic [2:0]    len_n;
  logic [RW-1:0] wreg_n;
  logic          data_en;

  always_comb begin
    addr_v_n = req_valid & dec.mem & ~dec.illegal;
    wb_v_n   = req_valid & (dec.upd != UPD_NONE) & ~dec.illegal;
    ill_n    = req_valid & dec.illegal;
    len_n    = (req_valid & ~dec.illegal) ? dec.ext_len : 3'd0;
    wreg_n   = (dec.upd == UPD_LEA) ? lea_dst : ea_field[RW-1:0];
    data_en  = req_valid;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_valid <= 1'b0;
      wb_valid   <= 1'b0;
      illegal    <= 1'b0;
      ext_len    <= '0;
    end else begin
      addr_valid <= addr_v_n;
      wb_valid   <= wb_v_n;
      illegal    <= ill_n;
      ext_len    <= len_n;
    end
  end

  // data registers, loaded under clock enable
  always_ff @(posedge clk) begin
    if (data_en) begin
      addr_out <= addr_c;
      wb_value <= wb_c;
      wb_reg   <= wreg_n;
    end
  end

  // assertions
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    illegal |-> (!addr_valid && !wb_valid)); // R9

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> (!addr_valid && !wb_valid && !illegal)); // R13

  AST_PREDEC_SAME: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && ea_field[5:3] == 3'b100 && !lea_op)
      |=> (addr_valid && wb_valid && wb_value == addr_out)); // R6

  AST_POSTINC_AHEAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && ea_field[5:3] == 3'b011 && !lea_op)
      |=> (addr_valid && wb_valid &&
           (wb_value - addr_out) == AW'(step_bytes($past(op_size))))); // R5

  AST_LEA_NO_MEM: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && lea_op) |=> !addr_valid); // R12

endmodule

// File: tb/eff_addr_unit_tb.sv
module eff_addr_unit_tb_top;

  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [31:0] PC   = 32'h0000_2000;

  typedef struct packed {
    logic [3:0]  rq;
    logic [5:0]  ea;
    logic        wr;
    logic        lea;
    logic [2:0]  dst;
    logic [1:0]  sz;
    logic [31:0] idx;
    logic        il;
    logic [1:0]  sc;
    logic [31:0] ext;
    logic        av;
    logic        wv;
    logic        ill;
    logic [31:0] addr;
    logic [31:0] wb;
    logic [2:0]  wreg;
    logic [2:0]  len;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{4'd3,  6'o23,1'b0,1'b0,3'd0,2'd2,32'h0,1'b1,2'd0,32'h0,        1'b1,1'b0,1'b0,32'h0000_1000,32'h0,3'd0,3'd0}, // R3
    '{4'd3,  6'o53,1'b0,1'b0,3'd0,2'd2,32'h0,1'b1,2'd0,32'h0000_FFF0,1'b1,1'b0,1'b0,32'h0000_0FF0,32'h0,3'd0,3'd2}, // R3
    '{4'd3,  6'o53,1'b1,1'b0,3'd0,2'd2,32'h0,1'b1,2'd0,32'h0000_0100,1'b1,1'b0,1'b0,32'h0000_1100,32'h0,3'd0,3'd2}, // R3
    '{4'd4,  6'o63,1'b0,1'b0,3'd0,2'd2,32'h10,1'b1,2'd2,32'h80,      1'b1,1'b0,1'b0,32'h0000_0FC0,32'h0,3'd0,3'd2}, // R4
    '{4'd4,  6'o63,1'b0,1'b0,3'd0,2'd2,32'h1234_FFFE,1'b0,2'd3,32'h5,1'b1,1'b0,1'b0,32'h0000_0FF5,32'h0,3'd0,3'd2}, // R4
    '{4'd5,  6'o33,1'b0,1'b0,3'd0,2'd2,32'h0,1'b1,2'd0,32'h0,        1'b1,1'b1,1'b0,32'h0000_1000,32'h0000_1004,3'd3,3'd0}, // R5
    '{4'd5,  6'o33,1'b1,1'b0,3'd0,2'd0,32'h0,1'b1,2'd0,32'h0,        1'b1,1'b1,1'b0,32'h0000_1000,32'h0000_1001,3'd3,3'd0}, // R5
    '{4'd6,  6'o43,1'b1,1'b0,3'd0,2'd1,32'h0,1'b1,2'd0,32'h0,        1'b1,1'b1,1'b0,32'h0000_0FFE,32'h0000_0FFE,3'd3,3'd0}, // R6
    '{4'd7,  6'o70,1'b0,1'b0,3'd0,2'd1,32'h0,1'b1,2'd0,32'h0000_8000,1'b1,1'b0,1'b0,32'hFFFF_8000,32'h0,3'd0,3'd2}, // R7
    '{4'd7,  6'o71,1'b1,1'b0,3'd0,2'd2,32'h0,1'b1,2'd0,32'h00AB_CDEF,1'b1,1'b0,1'b0,32'h00AB_CDEF,32'h0,3'd0,3'd4}, // R7
    '{4'd8,  6'o72,1'b0,1'b0,3'd0,2'd2,32'h0,1'b1,2'd0,32'h10,       1'b1,1'b0,1'b0,32'h0000_2010,32'h0,3'd0,3'd2}, // R8
    '{4'd8,  6'o73,1'b0,1'b0,3'd0,2'd2,32'h3,1'b1,2'd1,32'h4,        1'b1,1'b0,1'b0,32'h0000_200A,32'h0,3'd0,3'd2}, // R8
    '{4'd10, 6'o74,1'b0,1'b0,3'd0,2'd2,32'h0,1'b1,2'd0,32'h0,        1'b0,1'b0,1'b0,32'h0,32'h0,3'd0,3'd4}, // R10 R11
    '{4'd10, 6'o74,1'b0,1'b0,3'd0,2'd1,32'h0,1'b1,2'd0,32'h0,        1'b0,1'b0,1'b0,32'h0,32'h0,3'd0,3'd2}, // R10
    '{4'd9,  6'o75,1'b0,1'b0,3'd0,2'd2,32'h0,1'b1,2'd0,32'h0,        1'b0,1'b0,1'b1,32'h0,32'h0,3'd0,3'd0}, // R9
    '{4'd9,  6'o77,1'b0,1'b0,3'd0,2'd2,32'h0,1'b1,2'd0,32'h0,        1'b0,1'b0,1'b1,32'h0,32'h0,3'd0,3'd0}, // R9
    '{4'd9,  6'o72,1'b1,1'b0,3'd0,2'd2,32'h0,1'b1,2'd0,32'h10,       1'b0,1'b0,1'b1,32'h0,32'h0,3'd0,3'd0}, // R9
    '{4'd11, 6'o03,1'b1,1'b0,3'd0,2'd2,32'h0,1'b1,2'd0,32'h0,        1'b0,1'b0,1'b0,32'h0,32'h0,3'd0,3'd0}, // R11
    '{4'd12, 6'o53,1'b0,1'b1,3'd5,2'd2,32'h0,1'b1,2'd0,32'h0000_0100,1'b0,1'b1,1'b0,32'h0,32'h0000_1100,3'd5,3'd2}, // R12
    '{4'd9,  6'o33,1'b0,1'b1,3'd5,2'd2,32'h0,1'b1,2'd0,32'h0,        1'b0,1'b0,1'b1,32'h0,32'h0,3'd0,3'd0}, // R9
    '{4'd9,  6'o74,1'b1,1'b0,3'd0,2'd2,32'h0,1'b1,2'd0,32'h0,        1'b0,1'b0,1'b1,32'h0,32'h0,3'd0,3'd0}  // R9
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [5:0]  ea_field;
  logic        is_write, lea_op, idx_long;
  logic [2:0]  lea_dst;
  logic [1:0]  op_size, idx_scale;
  logic [31:0] base_val, pc_val, idx_val, ext_data;
  logic        addr_valid, wb_valid, illegal;
  logic [31:0] addr_out, wb_value;
  logic [2:0]  wb_reg, ext_len;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  eff_addr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ea_field(ea_field),
    .is_write(is_write), .lea_op(lea_op), .lea_dst(lea_dst), .op_size(op_size),
    .base_val(base_val), .pc_val(pc_val), .idx_val(idx_val), .idx_long(idx_long),
    .idx_scale(idx_scale), .ext_data(ext_data), .addr_valid(addr_valid),
    .addr_out(addr_out), .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_value(wb_value),
    .ext_len(ext_len), .illegal(illegal)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_valid = 1'b1;
    ea_field  = v.ea;
    is_write  = v.wr;
    lea_op    = v.lea;
    lea_dst   = v.dst;
    op_size   = v.sz;
    idx_val   = v.idx;
    idx_long  = v.il;
    idx_scale = v.sc;
    ext_data  = v.ext;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; ea_field = '0; is_write = 1'b0; lea_op = 1'b0;
    lea_dst = '0; op_size = '0; idx_val = '0; idx_long = 1'b0;
    idx_scale = '0; ext_data = '0;
    base_val = BASE; pc_val = PC;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "addr_valid", 32'(addr_valid), 32'h0);
    check("R1", "wb_valid",   32'(wb_valid),   32'h0);
    check("R1", "illegal",    32'(illegal),    32'h0);
    check("R1", "ext_len",    32'(ext_len),    32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "addr_valid after release", 32'(addr_valid), 32'h0);

    // vector stream, one request per clock (R2)
    drive(VECS[0]);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      begin
        vec_t v;
        string tg;
        v  = VECS[i];
        tg = $sformatf("R%0d", v.rq);
        check("R2", $sformatf("vec %0d addr_valid", i), 32'(addr_valid), 32'(v.av));
        check(tg, $sformatf("vec %0d wb_valid", i),     32'(wb_valid),   32'(v.wv));
        check(tg, $sformatf("vec %0d illegal", i),      32'(illegal),    32'(v.ill));
        check(tg, $sformatf("vec %0d ext_len", i),      32'(ext_len),    32'(v.len));
        if (v.av) check(tg, $sformatf("vec %0d addr", i), addr_out, v.addr);
        if (v.wv) begin
          check(tg, $sformatf("vec %0d wb_value", i), wb_value, v.wb);
          check(tg, $sformatf("vec %0d wb_reg", i), 32'(wb_reg), 32'(v.wreg));
        end
      end
      if (i + 1 < NV) drive(VECS[i+1]);
      else req_valid = 1'b0;
    end

    // R13: idle cycle clears valids
    @(negedge clk);
    check("R13", "addr_valid idle", 32'(addr_valid), 32'h0);
    check("R13", "wb_valid idle",   32'(wb_valid),   32'h0);
    check("R13", "illegal idle",    32'(illegal),    32'h0);

    // R5 with word size and a different base, back to back with R6
    base_val = 32'h0000_0100;
    drive('{4'd5, 6'o31, 1'b0, 1'b0, 3'd0, 2'd1, 32'h0, 1'b1, 2'd0, 32'h0,
            1'b1, 1'b1, 1'b0, 32'h100, 32'h102, 3'd1, 3'd0});
    @(negedge clk);
    check("R5", "word postinc addr", addr_out, 32'h0000_0100);
    check("R5", "word postinc wb",   wb_value, 32'h0000_0102);
    check("R5", "word postinc reg",  32'(wb_reg), 32'd1);
    drive('{4'd6, 6'o42, 1'b0, 1'b0, 3'd0, 2'd2, 32'h0, 1'b1, 2'd0, 32'h0,
            1'b1, 1'b1, 1'b0, 32'hFC, 32'hFC, 3'd2, 3'd0});
    @(negedge clk);
    check("R6", "long predec addr", addr_out, 32'h0000_00FC);
    check("R6", "long predec wb",   wb_value, 32'h0000_00FC);
    check("R6", "long predec both", 32'({addr_valid, wb_valid}), 32'h3);

    // R1: reset asserted while a result is held
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    #1;
    check("R1", "mid-run reset addr_valid", 32'(addr_valid), 32'h0);
    check("R1", "mid-run reset wb_valid",   32'(wb_valid),   32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "after re-release illegal", 32'(illegal), 32'h0);

    finish_run();
  end

endmodule